// File: doc/BRIEF.md
# Fractional Divide-Code Sequencer with Triangular Spread

This block produces, once per output clock cycle, the integer divide code that a downstream phase-interpolating divider consumes. The programmed ratio is expressed in 1/128 units as an integer field offset by -512, plus a fractional part held as a residue over a denominator. A first-order residue accumulator spreads the fraction across cycles, so that the long-run average of the emitted codes equals the programmed ratio exactly.

On top of the nominal ratio, an optional triangular spread profile can be applied. Each ramp step adds an integer increment and a residue increment, using the same denominator. The ramp is either centred on the nominal ratio or pulled entirely to one side of it (larger codes, which means lower output frequency). The ramp advances one step for each output cycle. The spread enable may be toggled at any time while codes are being produced.

Each cycle strobe yields one code, presented together with a single-cycle valid flag on the following clock.

Top module: `fdiv_ssc_top`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe, `code_o` reads 0 and `code_vld` reads 0.
- R2: `code_vld` is high exactly in the cycle after each `cyc_stb` cycle. Between strobes, `code_o` holds its last value.
- R3: The nominal code is `div_int` + 512 plus a carry bit. The residue accumulator starts at 0 after reset and adds `div_res` on every strobe. When the sum reaches `div_den`, it subtracts `div_den` and sets the carry. Over K strobes the number of carries is floor(K*`div_res`/`div_den`), provided `div_res` < `div_den`.
- R4: With `div_den` = 0, no carry is ever produced and every code equals `div_int` + 512.
- R5: The 2-bit `ssc_mode` encoding is: 1 = centre spread, 3 = down spread, 0 = off, 2 = reserved. Both 0 and 2, and any mode with `ssc_en` low, act as off. In the off state the spread offset and its phase counters are cleared and the codes are nominal only.
- R6: In down spread with N = `ssc_steps`, the offset added to code k of a period (k = 0..4N-1, offset taken before that strobe's step) rises by one step per code for 2N codes and then falls for 2N codes. With a zero step residue the codes peak at nominal + 2N*`ssc_step_int`, and the offsets over one period sum to 4N²*`ssc_step_int`.
- R7: In centre spread the offset rises for one quarter (N codes), falls for two quarters, then rises for one quarter. The codes span nominal ± N*`ssc_step_int`, and the offsets over one period sum to 0.
- R8: Each ramp step is `ssc_step_int` + `ssc_step_res`/`div_den` in 1/128 units. A separate spread residue carries on rising steps and borrows on falling steps. The integer offset is therefore the floor of the exact ramp value, and it returns to exactly 0 after 4N strobes.
- R9: When spread is turned off, the next code carries no offset, even if the strobe arrives in the same cycle. When spread is turned back on, the ramp restarts from offset 0 at the first quarter.
- R10: With `ssc_steps` = 0, spread stays off whatever the enable and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_stb | input | 1 | One pulse per output cycle; requests one code |
| div_int | input | 15 | Ratio integer part in 1/128 units, minus 512 |
| div_res | input | 15 | Ratio residue numerator |
| div_den | input | 15 | Shared residue denominator |
| ssc_en | input | 1 | Spread enable, may change at any time |
| ssc_mode | input | 2 | Spread mode code (1 centre, 3 down, 0/2 off) |
| ssc_steps | input | 12 | Ramp steps per quarter period |
| ssc_step_int | input | 12 | Integer step size in 1/128 units |
| ssc_step_res | input | 15 | Step residue numerator over `div_den` |
| code_o | output | 27 | Emitted divide code, two's complement |
| code_vld | output | 1 | High for one cycle after each strobe |

## Verification
The main function is exercised with a table of settings covering these cases:
- A disabled spread with a nonzero mode: no offset may leak through.
- Purely fractional nominal ratios: the carry count must match the floor formula.
- The reserved mode code: it must collapse to off.
- Down and centre ramps of several lengths: the sum over a full period separates the two profiles, and the extreme codes pin the peak.
- A mix of a nominal fraction with a down ramp: the two accumulators must not interfere.

Directed runs then cover the following:
- A fractional step residue, which must return exactly to zero after one period.
- Toggling the enable in mid-ramp.
- A zero denominator.
- A zero step count.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    typedef enum logic [1:0] {
        SSC_OFF    = 2'd0,
        SSC_CENTER = 2'd1,
        SSC_RSVD   = 2'd2,
        SSC_DOWN   = 2'd3
    } ssc_mode_e;

    localparam int RATIO_BIAS = 512;

    // Ramp direction for a quarter index: down spread rises in quarters 0,1;
    // centre spread rises in quarters 0 and 3.
    function automatic logic quarter_rises(ssc_mode_e m, logic [1:0] q);
        if (m == SSC_DOWN) return !q[1];
        return (q[1] == q[0]);
    endfunction

endpackage

// File: rtl/fdiv_res_acc.sv
module fdiv_res_acc #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic         clr,
    input  logic         sub,
    input  logic [W-1:0] inc,
    input  logic [W-1:0] den,
    output logic         carry,
    output logic [W-1:0] acc_q
);

    typedef struct packed {
        logic [W-1:0] acc;
    } st_t;

    st_t s_d, s_q;
    logic [W:0] sum;
    logic [W:0] dif;

    always_comb begin
        s_d   = s_q;
        carry = 1'b0;
        sum   = {1'b0, s_q.acc} + {1'b0, inc};
        dif   = {1'b0, s_q.acc} - {1'b0, inc};
        if (clr || den == '0) begin
            s_d.acc = '0;
        end else if (stb) begin
            if (!sub) begin
                if (sum >= {1'b0, den}) begin
                    s_d.acc = W'(sum - {1'b0, den});
                    carry   = 1'b1;
                end else begin
                    s_d.acc = sum[W-1:0];
                end
            end else begin
                if (dif[W]) begin
                    s_d.acc = dif[W-1:0] + den;
                    carry   = 1'b1;
                end else begin
                    s_d.acc = dif[W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign acc_q = s_q.acc;

    // R3 / R8: residue stays below the denominator it was reduced against
    a_r3_acc_below_den: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !clr && den != '0 && s_q.acc < den && inc < den)
        |=> (s_q.acc < $past(den)));

endmodule

// File: rtl/fdiv_ssc_phase.sv
module fdiv_ssc_phase #(
    parameter int NUM_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic             active,
    input  logic [1:0]       mode,
    input  logic [NUM_W-1:0] steps,
    output logic             rise,
    output logic [NUM_W-1:0] cnt_q,
    output logic [1:0]       qtr_q
);
    import fdiv_pkg::*;

    typedef struct packed {
        logic [NUM_W-1:0] cnt;
        logic [1:0]       qtr;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        rise = quarter_rises(ssc_mode_e'(mode), s_q.qtr);
        if (!active) begin
            s_d = '0;
        end else if (stb) begin
            if (s_q.cnt >= steps - NUM_W'(1)) begin
                s_d.cnt = '0;
                s_d.qtr = s_q.qtr + 2'd1;
            end else begin
                s_d.cnt = s_q.cnt + NUM_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_q = s_q.cnt;
    assign qtr_q = s_q.qtr;

endmodule

// File: rtl/fdiv_ssc_ramp.sv
module fdiv_ssc_ramp #(
    parameter int FRAC_W = 15,
    parameter int NUM_W  = 12,
    parameter int STEP_W = 12,
    localparam int OFS_W = STEP_W + NUM_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stb,
    input  logic                    en,
    input  logic [1:0]              mode,
    input  logic [NUM_W-1:0]        steps,
    input  logic [STEP_W-1:0]       step_int,
    input  logic [FRAC_W-1:0]       step_res,
    input  logic [FRAC_W-1:0]       den,
    output logic                    active,
    output logic signed [OFS_W-1:0] ofs_q
);
    import fdiv_pkg::*;

    typedef struct packed {
        logic signed [OFS_W-1:0] ofs;
    } st_t;

    st_t s_d, s_q;
    logic              rise;
    logic              rcarry;
    logic [FRAC_W-1:0] racc;
    logic [NUM_W-1:0]  cnt;
    logic [1:0]        qtr;
    logic [OFS_W-1:0]  delta;

    assign active = en && steps != '0 &&
                    (ssc_mode_e'(mode) == SSC_CENTER || ssc_mode_e'(mode) == SSC_DOWN);

    fdiv_ssc_phase #(.NUM_W(NUM_W)) i_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (stb),
        .active (active),
        .mode   (mode),
        .steps  (steps),
        .rise   (rise),
        .cnt_q  (cnt),
        .qtr_q  (qtr)
    );

    fdiv_res_acc #(.W(FRAC_W)) i_step_res (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (stb && active),
        .clr   (!active),
        .sub   (!rise),
        .inc   (step_res),
        .den   (den),
        .carry (rcarry),
        .acc_q (racc)
    );

    always_comb begin
        s_d   = s_q;
        delta = OFS_W'(step_int) + OFS_W'(rcarry);
        if (!active) begin
            s_d.ofs = '0;
        end else if (stb) begin
            if (rise) s_d.ofs = s_q.ofs + $signed(delta);
            else      s_d.ofs = s_q.ofs - $signed(delta);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ofs_q = s_q.ofs;

    // R5 / R9: an idle cycle leaves offset, residue and phase all at zero
    a_r5_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (s_q.ofs == '0 && racc == '0 && cnt == '0 && qtr == 2'd0));

    // R6: the offset moves only on strobes
    a_r6_ofs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !stb) |=> $stable(s_q.ofs));

endmodule

// File: rtl/fdiv_ssc_top.sv
module fdiv_ssc_top #(
    parameter int FRAC_W = 15,
    parameter int NUM_W  = 12,
    parameter int STEP_W = 12,
    localparam int OFS_W  = STEP_W + NUM_W + 2,
    localparam int CODE_W = ((OFS_W > FRAC_W + 1) ? OFS_W : FRAC_W + 1) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_stb,
    input  logic [FRAC_W-1:0] div_int,
    input  logic [FRAC_W-1:0] div_res,
    input  logic [FRAC_W-1:0] div_den,
    input  logic              ssc_en,
    input  logic [1:0]        ssc_mode,
    input  logic [NUM_W-1:0]  ssc_steps,
    input  logic [STEP_W-1:0] ssc_step_int,
    input  logic [FRAC_W-1:0] ssc_step_res,
    output logic [CODE_W-1:0] code_o,
    output logic              code_vld
);
    import fdiv_pkg::*;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              vld;
    } st_t;

    st_t s_d, s_q;
    logic                    ncarry;
    logic [FRAC_W-1:0]       nacc;
    logic                    sp_active;
    logic signed [OFS_W-1:0] sp_ofs;
    logic [CODE_W-1:0]       ofs_ext;

    fdiv_res_acc #(.W(FRAC_W)) i_nom_res (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (cyc_stb),
        .clr   (1'b0),
        .sub   (1'b0),
        .inc   (div_res),
        .den   (div_den),
        .carry (ncarry),
        .acc_q (nacc)
    );

    fdiv_ssc_ramp #(.FRAC_W(FRAC_W), .NUM_W(NUM_W), .STEP_W(STEP_W)) i_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (cyc_stb),
        .en       (ssc_en),
        .mode     (ssc_mode),
        .steps    (ssc_steps),
        .step_int (ssc_step_int),
        .step_res (ssc_step_res),
        .den      (div_den),
        .active   (sp_active),
        .ofs_q    (sp_ofs)
    );

    always_comb begin
        s_d     = s_q;
        ofs_ext = sp_active ? {{(CODE_W-OFS_W){sp_ofs[OFS_W-1]}}, sp_ofs} : '0;
        s_d.vld = cyc_stb;
        if (cyc_stb) begin
            s_d.code = CODE_W'(div_int) + CODE_W'(RATIO_BIAS) + CODE_W'(ncarry) + ofs_ext;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign code_o   = s_q.code;
    assign code_vld = s_q.vld;

    // R2: valid follows the strobe by exactly one cycle
    a_r2_vld_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_stb |=> code_vld);
    a_r2_no_spurious_vld: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_stb |=> !code_vld);
    a_r2_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_stb |=> $stable(code_o));
    // R4: with no denominator the nominal residue never moves
    a_r4_zero_den: assert property (@(posedge clk) disable iff (!rst_n)
        (div_den == '0) |=> (nacc == '0));

endmodule

// File: tb/test_fdiv_ssc_top.sv
`timescale 1ns/1ps
module test_fdiv_ssc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_stb = 1'b0;
    logic [14:0] div_int = '0, div_res = '0, div_den = 15'd1;
    logic        ssc_en = 1'b0;
    logic [1:0]  ssc_mode = 2'd0;
    logic [11:0] ssc_steps = '0, ssc_step_int = '0;
    logic [14:0] ssc_step_res = '0;
    logic [26:0] code_o;
    logic        code_vld;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    fdiv_ssc_top i_fdiv_ssc_top (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb),
        .div_int(div_int), .div_res(div_res), .div_den(div_den),
        .ssc_en(ssc_en), .ssc_mode(ssc_mode), .ssc_steps(ssc_steps),
        .ssc_step_int(ssc_step_int), .ssc_step_res(ssc_step_res),
        .code_o(code_o), .code_vld(code_vld)
    );

    typedef struct packed {
        int intg; int res; int den; int ena; int mode;
        int nst; int sint; int k; int esum; int emax; int emin;
    } vec_t;

    localparam vec_t VEC [0:6] = '{
        '{1000, 0, 1, 0, 3, 4,   5, 16, 24192, 1512, 1512}, // R5 enable low
        '{ 200, 3, 8, 1, 0, 4,   5, 16, 11398,  713,  712}, // R3 fraction, mode off
        '{ 200, 5, 7, 1, 2, 3,   4, 14,  9978,  713,  712}, // R5 reserved mode
        '{   0, 0, 5, 1, 3, 4,  10, 16,  8832,  592,  512}, // R6 down
        '{ 300, 0, 3, 1, 1, 5,   7, 20, 16240,  847,  777}, // R7 centre
        '{  50, 1, 2, 1, 3, 2,   3,  8,  4548,  574,  562}, // R3 + R6 mixed
        '{1000, 0, 1, 1, 1, 1, 100,  4,  6048, 1612, 1412}  // R7 short ramp
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        cyc_stb = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // called at a negedge; returns the code presented after the strobe
    task automatic strobe(output int c, output bit v);
        cyc_stb = 1'b1;
        @(negedge clk);
        cyc_stb = 1'b0;
        v = code_vld;
        c = int'(code_o);
    endtask

    task automatic cfg(input int intg, input int res, input int den, input int ena,
                       input int mode, input int nst, input int sint, input int sres);
        div_int      = 15'(intg);
        div_res      = 15'(res);
        div_den      = 15'(den);
        ssc_en       = ena[0];
        ssc_mode     = 2'(mode);
        ssc_steps    = 12'(nst);
        ssc_step_int = 12'(sint);
        ssc_step_res = 15'(sres);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int c, sum, mx, mn, vmiss;
        bit v;

        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 code in reset", int'(code_o), 0);
        chk("R1 valid in reset", int'(code_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 code after release", int'(code_o), 0);

        // table walk
        for (int i = 0; i < 7; i++) begin
            do_reset();
            cfg(VEC[i].intg, VEC[i].res, VEC[i].den, VEC[i].ena, VEC[i].mode,
                VEC[i].nst, VEC[i].sint, 0);
            sum = 0; mx = -1000000; mn = 1000000; vmiss = 0;
            for (int k = 0; k < VEC[i].k; k++) begin
                strobe(c, v);
                if (!v) vmiss++;
                sum += c;
                if (c > mx) mx = c;
                if (c < mn) mn = c;
            end
            chk($sformatf("R2 row%0d valid misses", i), vmiss, 0);
            chk($sformatf("R3/R6/R7 row%0d period sum", i), sum, VEC[i].esum);
            chk($sformatf("R6/R7 row%0d max code", i), mx, VEC[i].emax);
            chk($sformatf("R6/R7 row%0d min code", i), mn, VEC[i].emin);
        end

        // R2: single pulse, code held
        do_reset();
        cfg(7, 0, 1, 0, 0, 0, 0, 0);
        strobe(c, v);
        @(negedge clk);
        chk("R2 valid drops", int'(code_vld), 0);
        chk("R2 code held", int'(code_o), 519);

        // R4: zero denominator
        do_reset();
        cfg(10, 5, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 3; k++) begin
            strobe(c, v);
            chk("R4 zero den code", c, 522);
        end

        // R10: zero step count
        do_reset();
        cfg(20, 0, 1, 1, 3, 0, 9, 0);
        for (int k = 0; k < 4; k++) begin
            strobe(c, v);
            chk("R10 no steps code", c, 532);
        end

        // R8: fractional step 2 + 1/4, N=3, down
        do_reset();
        cfg(100, 0, 4, 1, 3, 3, 2, 1);
        sum = 0; mx = 0;
        for (int k = 0; k < 12; k++) begin
            strobe(c, v);
            sum += c;
            if (c > mx) mx = c;
        end
        chk("R8 fractional sum", sum, 7421);
        chk("R8 fractional peak", mx, 625);
        strobe(c, v);
        chk("R8 returns to zero", c, 612);

        // R9: enable toggling mid-ramp
        do_reset();
        cfg(0, 0, 1, 1, 3, 4, 10, 0);
        strobe(c, v); chk("R9 ramp k0", c, 512);
        strobe(c, v); chk("R9 ramp k1", c, 522);
        strobe(c, v); chk("R9 ramp k2", c, 532);
        ssc_en = 1'b0;
        strobe(c, v); chk("R9 off same cycle", c, 512);
        strobe(c, v); chk("R9 off stays nominal", c, 512);
        ssc_en = 1'b1;
        strobe(c, v); chk("R9 restart from zero", c, 512);
        strobe(c, v); chk("R9 restart first step", c, 522);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule